// File: doc/BRIEF.md
# Burst-of-Two Split-Port Double-Rate SRAM Core

This block is a cycle model of a static memory with two independent ports: a write-only port and a read-only port that share no data pins. Every location holds a pair of words that always move together as a two-word burst. The read port and the write port can each start one burst per memory cycle, and both can start one in the same cycle.

The double-rate timing is modelled with a single clock `clk` at twice the memory-cycle rate. Each memory cycle has two halves. The first half begins on a "K-rise" edge, and output `k_half` is 0 just before that edge. The second half begins on a "K-fall" edge, and `k_half` is 1 just before it. Commands and the first write word are sampled on K-rise edges, and the second write word on the following K-fall edge. Read data comes back one and a half memory cycles after the read command: first word, then second word, each for one half-cycle, marked by `rd_valid`.

Per-byte-lane write enables allow partial writes. If a write and a read to the same address start in the same cycle, the read returns the new data, including the second word, which is still on the write data pins. A read that started before a write to the same address returns the old contents.

Top module: `qb2_sram`

## Requirements
- R1: `k_half` is 0 in reset. It toggles on every `clk` edge after reset, so the Nth edge after reset release is a K-rise edge when N is odd. Commands and addresses are sampled only on K-rise edges (`k_half`==0 before the edge).
- R2: During reset, `rd_valid` is 0 and `rd_data` is all zeros.
- R3: A write starts when `wr_sel_n` is low on a K-rise edge. The edge stores `wr_data` as word 0 of `wr_addr`. The next edge (K-fall) stores `wr_data` as word 1 of the same address.
- R4: A read started on K-rise edge T (`rd_sel_n` low, address `rd_addr`) puts word 0 on `rd_data` from edge T+3 and word 1 from edge T+4. `rd_valid` is 1 during exactly those two half-cycles, and it is 0 in every half-cycle with no read data due.
- R5: With LANES lanes of DATA_W/LANES bits, lane i is bits [i*DATA_W/LANES +: DATA_W/LANES]. A low bit i of `wr_bw_n`, sampled with each word, writes lane i of that word. A high bit leaves that lane unchanged.
- R6: A read and a write to the same address started on the same K-rise edge return the newly written words, merged with the unwritten lanes of the old contents.
- R7: A read started one memory cycle before a write to the same address returns the contents from before that write.
- R8: When `wr_sel_n` is high on a K-rise edge, nothing is written and `wr_addr` is ignored. When `rd_sel_n` is high, no read data is produced. Both selects and both addresses are ignored on K-fall edges.
- R9: While `rd_valid` is 0, `rd_data` keeps its last value.
- R10: Reads and writes can start on every K-rise edge, together and back to back, with no lost or reordered data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; alternate edges are K-rise and K-fall |
| rst_n | input | 1 | Active-low synchronous reset |
| k_half | output | 1 | Current half of the memory cycle; 0 before a K-rise edge |
| rd_sel_n | input | 1 | Active-low read start, sampled on K-rise edges |
| rd_addr | input | ADDR_W | Read burst address |
| wr_sel_n | input | 1 | Active-low write start, sampled on K-rise edges |
| wr_addr | input | ADDR_W | Write burst address |
| wr_data | input | DATA_W | Write word 0 on K-rise edges, word 1 on K-fall edges |
| wr_bw_n | input | LANES | Active-low byte-lane write enables, sampled with each word |
| rd_data | output | DATA_W | Read word |
| rd_valid | output | 1 | High during the two half-cycles that carry a read burst |

## Verification
The assertions assume that `rd_sel_n` is driven to a known level on every K-rise edge and that reset lasts at least one edge. The latency properties also assume reset is not asserted in the middle of a read burst. The stimulus drives all inputs on the falling edge of `clk`. It keeps the selects at 0 or 1 throughout and releases reset once, at a point where the next edge is a K-rise edge. It fills every location before any random read, so that no expected value depends on the contents the memory has at power-up.

// File: rtl/qb2_pkg.sv
`timescale 1ns/1ps
package qb2_pkg;
   // half of the memory cycle that the next clk edge opens
   typedef enum logic {
      HALF_K  = 1'b0,   // next edge is a K-rise edge (commands, word 0)
      HALF_KB = 1'b1    // next edge is a K-fall edge (word 1)
   } half_e;
endpackage

// File: rtl/qb2_array.sv
`timescale 1ns/1ps
module qb2_array #(
   parameter int DATA_W = 18,
   parameter int LANES  = 2,
   parameter int DEPTH  = 256,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int LW     = DATA_W / LANES
) (
   input  logic              clk,
   input  logic              we,
   input  logic              wword,     // 0: word 0, 1: word 1
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LANES-1:0]  wbe_n,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata0,
   output logic [DATA_W-1:0] rdata1
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LW-1:0] m0 [DEPTH];
      logic [LW-1:0] m1 [DEPTH];

      always_ff @(posedge clk) begin
         if (we && !wbe_n[g]) begin
            if (wword) m1[waddr] <= wdata[g*LW +: LW];
            else       m0[waddr] <= wdata[g*LW +: LW];
         end
      end

      assign rdata0[g*LW +: LW] = m0[raddr];
      assign rdata1[g*LW +: LW] = m1[raddr];
   end
endmodule

// File: rtl/qb2_rd_pipe.sv
`timescale 1ns/1ps
module qb2_rd_pipe
   import qb2_pkg::*;
#(
   parameter int DATA_W = 18,
   parameter int LANES  = 2,
   parameter int ADDR_W = 8,
   localparam int LW    = DATA_W / LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  half_e             ph,
   input  logic              rd_sel_n,
   input  logic [ADDR_W-1:0] rd_addr,
   // second write word in flight this edge
   input  logic              w1_we,
   input  logic [ADDR_W-1:0] w1_addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LANES-1:0]  wbe_n,
   // array read port
   output logic [ADDR_W-1:0] raddr,
   input  logic [DATA_W-1:0] arr0,
   input  logic [DATA_W-1:0] arr1,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   logic              a_v, b_v, c_v, d_v;
   logic [ADDR_W-1:0] a_addr;
   logic [DATA_W-1:0] snap0, snap1, hold1;
   logic [DATA_W-1:0] fmask, w1_merged;
   logic              fwd_hit;

   for (genvar g = 0; g < LANES; g++) begin : g_mask
      assign fmask[g*LW +: LW] = {LW{~wbe_n[g]}};
   end

   assign raddr     = a_addr;
   assign fwd_hit   = w1_we && (w1_addr == a_addr);
   assign w1_merged = fwd_hit ? ((arr1 & ~fmask) | (wdata & fmask)) : arr1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_v      <= 1'b0;
         b_v      <= 1'b0;
         c_v      <= 1'b0;
         d_v      <= 1'b0;
         a_addr   <= '0;
         snap0    <= '0;
         snap1    <= '0;
         hold1    <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         // edge T: command
         a_v <= (ph == HALF_K) && !rd_sel_n;
         if (ph == HALF_K) a_addr <= rd_addr;
         // edge T+1: snapshot both words, forwarding the in-flight word 1
         b_v <= a_v;
         if (a_v) begin
            snap0 <= arr0;
            snap1 <= w1_merged;
         end
         // edge T+2: wait half a cycle
         c_v <= b_v;
         // edge T+3: word 0 out; edge T+4: word 1 out
         d_v <= c_v;
         if (c_v) begin
            rd_data <= snap0;
            hold1   <= snap1;
         end else if (d_v) begin
            rd_data <= hold1;
         end
         rd_valid <= c_v || d_v;
      end
   end
endmodule

// File: rtl/qb2_sram.sv
`timescale 1ns/1ps
module qb2_sram
   import qb2_pkg::*;
#(
   parameter int DATA_W = 18,
   parameter int LANES  = 2,
   parameter int DEPTH  = 256,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              k_half,
   input  logic              rd_sel_n,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wr_sel_n,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LANES-1:0]  wr_bw_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   if (LANES < 1 || DATA_W % LANES != 0) begin : g_bad_lanes
      $error("qb2_sram: DATA_W must split evenly into LANES lanes");
   end
   if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("qb2_sram: DEPTH must be a power of two of at least 2");
   end

   half_e             ph;
   logic              wr_act_q;
   logic [ADDR_W-1:0] wr_addr_q;
   logic              arr_we, arr_word, w1_we;
   logic [ADDR_W-1:0] arr_waddr, arr_raddr;
   logic [DATA_W-1:0] arr0, arr1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph        <= HALF_K;
         wr_act_q  <= 1'b0;
         wr_addr_q <= '0;
      end else begin
         ph       <= (ph == HALF_K) ? HALF_KB : HALF_K;
         wr_act_q <= (ph == HALF_K) && !wr_sel_n;
         if (ph == HALF_K) wr_addr_q <= wr_addr;
      end
   end

   assign k_half    = (ph == HALF_KB);
   assign w1_we     = (ph == HALF_KB) && wr_act_q;
   assign arr_we    = (ph == HALF_K) ? !wr_sel_n : w1_we;
   assign arr_word  = (ph == HALF_KB);
   assign arr_waddr = (ph == HALF_K) ? wr_addr : wr_addr_q;

   qb2_array #(.DATA_W(DATA_W), .LANES(LANES), .DEPTH(DEPTH)) i_array (
      .clk    (clk),
      .we     (arr_we),
      .wword  (arr_word),
      .waddr  (arr_waddr),
      .wdata  (wr_data),
      .wbe_n  (wr_bw_n),
      .raddr  (arr_raddr),
      .rdata0 (arr0),
      .rdata1 (arr1)
   );

   qb2_rd_pipe #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) i_rd_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .ph       (ph),
      .rd_sel_n (rd_sel_n),
      .rd_addr  (rd_addr),
      .w1_we    (w1_we),
      .w1_addr  (wr_addr_q),
      .wdata    (wr_data),
      .wbe_n    (wr_bw_n),
      .raddr    (arr_raddr),
      .arr0     (arr0),
      .arr1     (arr1),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );
endmodule

// File: rtl/qb2_sram_chk.sv
`timescale 1ns/1ps
module qb2_sram_chk #(
   parameter int DATA_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              k_half,
   input logic              rd_sel_n,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_valid
);
   // R1: the half indicator alternates on every edge after reset
   a_r1_half_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (k_half != $past(k_half)));

   // R4: a read started on a K-rise edge yields two valid half-cycles after 1.5 cycles
   a_r4_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (!k_half && !rd_sel_n) |-> ##4 rd_valid ##1 rd_valid);

   // R4: a burst never lasts a single half-cycle
   a_r4_burst_pair: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |=> rd_valid);

   // R8: read data only appears after a read start
   a_r8_no_spurious_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> $past(!k_half && !rd_sel_n, 4));

   // R9: read data holds between bursts
   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> $stable(rd_data));
endmodule

bind qb2_sram qb2_sram_chk #(.DATA_W(DATA_W)) i_qb2_sram_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .k_half   (k_half),
   .rd_sel_n (rd_sel_n),
   .rd_data  (rd_data),
   .rd_valid (rd_valid)
);

// File: tb/test_qb2_sram.sv
`timescale 1ns/1ps
module test_qb2_sram;
   localparam int DW = 18;
   localparam int NL = 2;
   localparam int LW = DW / NL;
   localparam int DP = 256;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          k_half;
   logic          rd_sel_n = 1'b1;
   logic [AW-1:0] rd_addr = '0;
   logic          wr_sel_n = 1'b1;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [NL-1:0] wr_bw_n = '1;
   logic [DW-1:0] rd_data;
   logic          rd_valid;

   always #2 clk = ~clk;   // 250 MHz

   qb2_sram #(.DATA_W(DW), .LANES(NL), .DEPTH(DP)) i_qb2_sram (
      .clk(clk), .rst_n(rst_n), .k_half(k_half),
      .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
      .wr_sel_n(wr_sel_n), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_bw_n(wr_bw_n),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [DW-1:0] ref0 [DP];
   logic [DW-1:0] ref1 [DP];

   // expectation slots indexed by edge number modulo 16
   bit            ev [16];
   logic [DW-1:0] ed [16];
   string         et [16];
   int            edge_t;   // number of the next edge (driver side)

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                           input logic [DW-1:0] new_w,
                                           input logic [NL-1:0] bn);
      logic [DW-1:0] r = old_w;
      for (int i = 0; i < NL; i++)
         if (!bn[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
      return r;
   endfunction

   // one memory cycle; called just before a K-rise edge
   task automatic kcycle(input bit rd, input logic [AW-1:0] ra,
                         input bit wr, input logic [AW-1:0] wa,
                         input logic [DW-1:0] d0, input logic [NL-1:0] b0,
                         input logic [DW-1:0] d1, input logic [NL-1:0] b1,
                         input string tag);
      rd_sel_n = !rd;
      rd_addr  = rd ? ra : AW'($urandom);
      wr_sel_n = !wr;
      wr_addr  = wr ? wa : AW'($urandom);
      wr_data  = d0;
      wr_bw_n  = b0;
      if (wr) begin
         ref0[wa] = merge(ref0[wa], d0, b0);
         ref1[wa] = merge(ref1[wa], d1, b1);
      end
      if (rd) begin
         ev[(edge_t + 3) % 16] = 1'b1;
         ed[(edge_t + 3) % 16] = ref0[ra];
         et[(edge_t + 3) % 16] = {tag, " word0"};
         ev[(edge_t + 4) % 16] = 1'b1;
         ed[(edge_t + 4) % 16] = ref1[ra];
         et[(edge_t + 4) % 16] = {tag, " word1"};
      end
      @(negedge clk);
      // K-fall half: selects and addresses are garbage and must be ignored (R8)
      rd_sel_n = 1'($urandom);
      wr_sel_n = 1'($urandom);
      rd_addr  = AW'($urandom);
      wr_addr  = AW'($urandom);
      wr_data  = d1;
      wr_bw_n  = b1;
      @(negedge clk);
      edge_t += 2;
   endtask

   task automatic idle(input string tag);
      kcycle(1'b0, '0, 1'b0, '0, DW'($urandom), NL'($urandom),
             DW'($urandom), NL'($urandom), tag);
   endtask

   // monitor: one sample after every edge
   initial begin
      int n = 0;
      logic [DW-1:0] last = '0;
      wait (rst_n === 1'b1);
      forever begin
         @(negedge clk);
         n++;
         check(k_half == n[0], "R1 half toggle", DW'(k_half), DW'(n[0]));
         if (ev[n % 16]) begin
            check(rd_valid === 1'b1, {et[n % 16], " R4 valid"}, DW'(rd_valid), DW'(1));
            check(rd_data === ed[n % 16], et[n % 16], rd_data, ed[n % 16]);
            ev[n % 16] = 1'b0;
         end else begin
            check(rd_valid === 1'b0, "R4/R8 no data due", DW'(rd_valid), DW'(0));
            check(rd_data === last, "R9 hold when idle", rd_data, last);
         end
         last = rd_data;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 16; i++) ev[i] = 1'b0;
      repeat (4) @(negedge clk);
      // R2: reset state
      check(rd_valid === 1'b0, "R2 reset valid", DW'(rd_valid), DW'(0));
      check(rd_data === '0, "R2 reset data", rd_data, '0);
      check(k_half === 1'b0, "R1 reset half", DW'(k_half), DW'(0));
      rst_n  = 1'b1;
      edge_t = 1;

      // fill every location, reading already-written ones alongside (R3, R10)
      for (int a = 0; a < DP; a++) begin
         kcycle(a > 0, AW'(a > 0 ? $urandom % a : 0), 1'b1, AW'(a),
                DW'($urandom), '0, DW'($urandom), '0, "R3 R10 fill");
      end

      // R8: deselected write with garbage must not change location 5
      idle("R8 idle");
      kcycle(1'b1, 8'd5, 1'b0, 8'd5, DW'($urandom), '0, DW'($urandom), '0, "R8 deselected write");

      // R6 + R5: same-cycle read and partial write to the same address
      kcycle(1'b1, 8'd10, 1'b1, 8'd10, 18'h2AAAA, 2'b10, 18'h15555, 2'b01, "R6 R5 same-cycle fwd");
      kcycle(1'b1, 8'd11, 1'b1, 8'd11, 18'h3FFFF, 2'b00, 18'h00123, 2'b00, "R6 full fwd");

      // R7: read one cycle ahead of a write to the same address sees old data
      kcycle(1'b1, 8'd20, 1'b0, 8'd0, '0, '1, '0, '1, "R7 read before write");
      kcycle(1'b0, 8'd0, 1'b1, 8'd20, 18'h0BEEF, 2'b00, 18'h1CAFE, 2'b00, "R7 write");
      // R3: write then read the next cycle sees new data
      kcycle(1'b1, 8'd20, 1'b0, 8'd0, '0, '1, '0, '1, "R3 read after write");

      // R5: all lanes disabled writes nothing
      kcycle(1'b0, 8'd0, 1'b1, 8'd30, 18'h3FFFF, 2'b11, 18'h3FFFF, 2'b11, "R5 no lanes");
      kcycle(1'b1, 8'd30, 1'b0, 8'd0, '0, '1, '0, '1, "R5 no lanes readback");
      idle("R9 gap");
      idle("R9 gap");

      // random back-to-back traffic, biased to a few addresses for collisions
      for (int i = 0; i < 400; i++) begin
         logic [AW-1:0] ra = ($urandom % 2) ? AW'($urandom % 4) : AW'($urandom);
         logic [AW-1:0] wa = ($urandom % 2) ? AW'($urandom % 4) : AW'($urandom);
         kcycle(($urandom % 4) != 0, ra, ($urandom % 4) != 0, wa,
                DW'($urandom), NL'($urandom), DW'($urandom), NL'($urandom),
                "R10 R5 random");
      end
      repeat (4) idle("drain");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule